// File: doc/BRIEF.md
# MAC control and interrupt register block

This block is the 32-bit, word-addressed control and status register file of an Ethernet MAC controller. Software reaches it through a simple bus: an address, a write strobe with write data, and a read data output that always shows the word at the current address. Through it software sets the command bits that switch transmission and reception on and allow long frames. It also programs the interrupt enables and the descriptor list base and current pointers, and it reads the configuration words that come out of reset with non-zero values.

The transmit and receive DMA engines report events as one-cycle pulses on two 16-bit event vectors. Each pulse sets the matching bit in the upper (transmit) or lower (receive) half of the interrupt status word. Software clears a status bit by writing 1 to it. Each half is masked by the matching half of the enable word and drives its own interrupt line.

Setting the self-clearing reset bit in the command word starts a soft reset that lasts a fixed number of cycles. For that time every read returns zero, writes and events are dropped, and every register returns to its reset value. The descriptor list base registers only accept new values between a reset and the moment software next enables transmission or reception.

Top module: `mac_csr_block`

## Requirements
- R1: After the asynchronous reset, the words read as follows: command (word 0) 0, interrupt enable (1) 0, interrupt status (2) 0, transmit list base (3) 0xFFFFFFFC, receive list base (4) 0xFFFFFFFC, transmit current pointer (5) 0, receive current pointer (6) 0, FIFO threshold (7) 0x0101, receive frame-size limit (8) 0x0800, missed-frame counter (9) 0x7FFF, management data/address (10) 0x00900000. All outputs are low.
- R2: The command word holds receive-on at bit 0, long-frame accept at bit 1, transmit-on at bit 8 and soft reset at bit 24. Its other bits read 0. Outputs rx_run, long_ok and tx_run follow bits 0, 1 and 8.
- R3: Writing the command word with bit 24 set raises reset_busy for exactly SRST_CYCLES cycles, starting with the clock edge that takes the write. While reset_busy is high, every read returns 0. Afterwards all words hold their R1 values, and bit 24 reads 0.
- R4: While reset_busy is high, bus writes and event pulses have no effect.
- R5: An event pulse on tx_evt[i] sets status bit 16+i, and one on rx_evt[i] sets status bit i, at the next edge. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a clear hit the same bit in one cycle, the bit ends up set.
- R6: irq_tx is high when any of status bits 31:16 is set together with the same enable bit. irq_rx does the same for bits 15:0. An enabled bit in one half never drives the other half's line.
- R7: The list base words (3 and 4) accept writes only while unlocked, and their bits 1:0 always read 0. Both reset kinds unlock them. A command write that sets bit 0 or bit 8 locks them.
- R8: The enable, current pointer, FIFO threshold, frame-size limit and management words store all 32 written bits. The missed-frame counter word ignores writes.
- R9: Addresses 11 and above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the word at bus_addr |
| tx_evt | input | 16 | Transmit DMA event pulses, set status bits 31:16 |
| rx_evt | input | 16 | Receive DMA event pulses, set status bits 15:0 |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| tx_run | output | 1 | Transmission enabled |
| rx_run | output | 1 | Reception enabled |
| long_ok | output | 1 | Long frames accepted |
| reset_busy | output | 1 | Soft reset in progress |

## Verification
The collision of interest is a DMA event and a software write-1-to-clear landing on the status word in the same cycle. The bench drives an event pulse and a status write on the same clock edge: once on the same bit, and once on bits in opposite halves. It expects the common bit to stay set, the cleared bit to drop and the new bit to appear. It also collides soft reset with later writes and event pulses inside the reset window, and then expects every word to show its reset value.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;

    localparam int unsigned REG_W = 32;

    // word addresses
    localparam int unsigned A_CMD     = 0;
    localparam int unsigned A_IEN     = 1;
    localparam int unsigned A_ISR     = 2;
    localparam int unsigned A_TXBASE  = 3;
    localparam int unsigned A_RXBASE  = 4;
    localparam int unsigned A_TXCUR   = 5;
    localparam int unsigned A_RXCUR   = 6;
    localparam int unsigned A_FIFOTH  = 7;
    localparam int unsigned A_RXMAX   = 8;
    localparam int unsigned A_MISS    = 9;
    localparam int unsigned A_MDIO    = 10;

    // command word bit positions
    localparam int unsigned CMD_RXON  = 0;
    localparam int unsigned CMD_LONG  = 1;
    localparam int unsigned CMD_TXON  = 8;
    localparam int unsigned CMD_SRST  = 24;

    // reset values
    localparam logic [REG_W-1:0] RST_LIST_BASE = 32'hFFFF_FFFC;
    localparam logic [REG_W-1:0] RST_FIFO_TH   = 32'h0000_0101;
    localparam logic [REG_W-1:0] RST_RX_MAX    = 32'h0000_0800;
    localparam logic [REG_W-1:0] RST_MISS_CNT  = 32'h0000_7FFF;
    localparam logic [REG_W-1:0] RST_MDIO      = 32'h0090_0000;

    typedef struct packed {
        logic             tx_on;
        logic             rx_on;
        logic             long_ok;
        logic             unlock;
        logic [REG_W-1:0] ien;
        logic [REG_W-1:0] tx_base;
        logic [REG_W-1:0] rx_base;
        logic [REG_W-1:0] tx_cur;
        logic [REG_W-1:0] rx_cur;
        logic [REG_W-1:0] fifo_th;
        logic [REG_W-1:0] rx_max;
        logic [REG_W-1:0] mdio;
    } csr_regs_t;

    function automatic csr_regs_t csr_regs_default();
        csr_regs_t r;
        r         = '0;
        r.unlock  = 1'b1;
        r.tx_base = RST_LIST_BASE;
        r.rx_base = RST_LIST_BASE;
        r.fifo_th = RST_FIFO_TH;
        r.rx_max  = RST_RX_MAX;
        r.mdio    = RST_MDIO;
        return r;
    endfunction

endpackage

// File: rtl/mac_csr_srst_seq.sv
module mac_csr_srst_seq #(
    parameter int unsigned CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = CNT_W'(CYCLES - 1);
        end else if (seq_q.busy) begin
            if (seq_q.cnt == '0) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.cnt = seq_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = seq_q.busy;

endmodule

// File: rtl/mac_csr_irq_half.sv
module mac_csr_irq_half #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hold,
    input  logic [W-1:0] set_evt,
    input  logic [W-1:0] w1c,
    input  logic [W-1:0] ien,
    output logic [W-1:0] stat,
    output logic         irq
);
    logic [W-1:0] stat_d, stat_q;

    // clear-by-write first, event set last: set wins on collision
    always_comb begin
        if (clr) begin
            stat_d = '0;
        end else if (hold) begin
            stat_d = stat_q;
        end else begin
            stat_d = (stat_q & ~w1c) | set_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat = stat_q;
    assign irq  = |(stat_q & ien);

endmodule

// File: rtl/mac_csr_block.sv
module mac_csr_block
    import mac_csr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SRST_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [REG_W/2-1:0]   tx_evt,
    input  logic [REG_W/2-1:0]   rx_evt,
    output logic                 irq_tx,
    output logic                 irq_rx,
    output logic                 tx_run,
    output logic                 rx_run,
    output logic                 long_ok,
    output logic                 reset_busy
);
    localparam int unsigned HALF_W = REG_W / 2;

    localparam logic [ADDR_W-1:0] ADR_CMD    = ADDR_W'(A_CMD);
    localparam logic [ADDR_W-1:0] ADR_IEN    = ADDR_W'(A_IEN);
    localparam logic [ADDR_W-1:0] ADR_ISR    = ADDR_W'(A_ISR);
    localparam logic [ADDR_W-1:0] ADR_TXBASE = ADDR_W'(A_TXBASE);
    localparam logic [ADDR_W-1:0] ADR_RXBASE = ADDR_W'(A_RXBASE);
    localparam logic [ADDR_W-1:0] ADR_TXCUR  = ADDR_W'(A_TXCUR);
    localparam logic [ADDR_W-1:0] ADR_RXCUR  = ADDR_W'(A_RXCUR);
    localparam logic [ADDR_W-1:0] ADR_FIFOTH = ADDR_W'(A_FIFOTH);
    localparam logic [ADDR_W-1:0] ADR_RXMAX  = ADDR_W'(A_RXMAX);
    localparam logic [ADDR_W-1:0] ADR_MISS   = ADDR_W'(A_MISS);
    localparam logic [ADDR_W-1:0] ADR_MDIO   = ADDR_W'(A_MDIO);

    csr_regs_t q, d;

    logic wr_ok;
    logic srst_start;
    logic isr_wr;

    assign wr_ok      = bus_wr && !reset_busy;
    assign srst_start = wr_ok && (bus_addr == ADR_CMD) && bus_wdata[CMD_SRST];
    assign isr_wr     = wr_ok && (bus_addr == ADR_ISR);

    // ---------------- soft reset sequencer ----------------
    mac_csr_srst_seq #(
        .CYCLES (SRST_CYCLES)
    ) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (reset_busy)
    );

    // ---------------- status halves: [0] receive, [1] transmit ----------------
    logic [1:0][HALF_W-1:0] evt_h;
    logic [1:0][HALF_W-1:0] ien_h;
    logic [1:0][HALF_W-1:0] w1c_h;
    logic [1:0][HALF_W-1:0] stat_h;
    logic [1:0]             irq_h;

    assign evt_h[0] = rx_evt;
    assign evt_h[1] = tx_evt;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_half
            assign ien_h[g] = q.ien[g*HALF_W +: HALF_W];
            assign w1c_h[g] = isr_wr ? bus_wdata[g*HALF_W +: HALF_W] : '0;

            mac_csr_irq_half #(
                .W (HALF_W)
            ) u_half (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (srst_start),
                .hold    (reset_busy),
                .set_evt (evt_h[g]),
                .w1c     (w1c_h[g]),
                .ien     (ien_h[g]),
                .stat    (stat_h[g]),
                .irq     (irq_h[g])
            );
        end
    endgenerate

    assign irq_rx = irq_h[0];
    assign irq_tx = irq_h[1];

    // ---------------- register next state ----------------
    always_comb begin
        d = q;
        if (srst_start) begin
            d = csr_regs_default();
        end else if (wr_ok) begin
            case (bus_addr)
                ADR_CMD: begin
                    d.tx_on   = bus_wdata[CMD_TXON];
                    d.rx_on   = bus_wdata[CMD_RXON];
                    d.long_ok = bus_wdata[CMD_LONG];
                    if (bus_wdata[CMD_TXON] || bus_wdata[CMD_RXON]) begin
                        d.unlock = 1'b0;
                    end
                end
                ADR_IEN:    d.ien = bus_wdata;
                ADR_TXBASE: begin
                    if (q.unlock) begin
                        d.tx_base = {bus_wdata[REG_W-1:2], 2'b00};
                    end
                end
                ADR_RXBASE: begin
                    if (q.unlock) begin
                        d.rx_base = {bus_wdata[REG_W-1:2], 2'b00};
                    end
                end
                ADR_TXCUR:  d.tx_cur  = bus_wdata;
                ADR_RXCUR:  d.rx_cur  = bus_wdata;
                ADR_FIFOTH: d.fifo_th = bus_wdata;
                ADR_RXMAX:  d.rx_max  = bus_wdata;
                ADR_MDIO:   d.mdio    = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= csr_regs_default();
        end else begin
            q <= d;
        end
    end

    // ---------------- read path ----------------
    always_comb begin
        bus_rdata = '0;
        if (!reset_busy) begin
            case (bus_addr)
                ADR_CMD: begin
                    bus_rdata[CMD_TXON] = q.tx_on;
                    bus_rdata[CMD_RXON] = q.rx_on;
                    bus_rdata[CMD_LONG] = q.long_ok;
                end
                ADR_IEN:    bus_rdata = q.ien;
                ADR_ISR:    bus_rdata = {stat_h[1], stat_h[0]};
                ADR_TXBASE: bus_rdata = q.tx_base;
                ADR_RXBASE: bus_rdata = q.rx_base;
                ADR_TXCUR:  bus_rdata = q.tx_cur;
                ADR_RXCUR:  bus_rdata = q.rx_cur;
                ADR_FIFOTH: bus_rdata = q.fifo_th;
                ADR_RXMAX:  bus_rdata = q.rx_max;
                ADR_MISS:   bus_rdata = RST_MISS_CNT;
                ADR_MDIO:   bus_rdata = q.mdio;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign tx_run  = q.tx_on;
    assign rx_run  = q.rx_on;
    assign long_ok = q.long_ok;

endmodule

// File: rtl/mac_csr_checker.sv
module mac_csr_checker #(
    parameter int unsigned HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                srst_start,
    input logic                reset_busy,
    input logic [2*HALF_W-1:0] bus_rdata,
    input logic                irq_tx,
    input logic                irq_rx,
    input logic [HALF_W-1:0]   tx_evt,
    input logic [HALF_W-1:0]   rx_evt,
    input logic [HALF_W-1:0]   tx_stat,
    input logic [HALF_W-1:0]   rx_stat,
    input logic                base_unlock,
    input logic [2*HALF_W-1:0] tx_base,
    input logic [2*HALF_W-1:0] rx_base
);
    // R3: a soft reset request opens the busy window at the next edge
    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        srst_start |=> reset_busy);

    // R3: nothing readable while busy
    a_r3_busy_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reset_busy |-> (bus_rdata == '0));

    // R4 / R6: no interrupt line during the reset window
    a_r6_irq_low_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        reset_busy |-> (!irq_tx && !irq_rx));

    // R5: an event outside reset always lands, even against a clear
    a_r5_rx_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_busy && !srst_start) |=> ((rx_stat & $past(rx_evt)) == $past(rx_evt)));

    a_r5_tx_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_busy && !srst_start) |=> ((tx_stat & $past(tx_evt)) == $past(tx_evt)));

    // R7: locked list bases never move outside a soft reset
    a_r7_base_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_unlock && !reset_busy && !srst_start) |=> ($stable(tx_base) && $stable(rx_base)));

endmodule

bind mac_csr_block mac_csr_checker #(
    .HALF_W (HALF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst_start  (srst_start),
    .reset_busy  (reset_busy),
    .bus_rdata   (bus_rdata),
    .irq_tx      (irq_tx),
    .irq_rx      (irq_rx),
    .tx_evt      (tx_evt),
    .rx_evt      (rx_evt),
    .tx_stat     (stat_h[1]),
    .rx_stat     (stat_h[0]),
    .base_unlock (q.unlock),
    .tx_base     (q.tx_base),
    .rx_base     (q.rx_base)
);

// File: tb/mac_csr_block_tb.sv
module mac_csr_block_tb;
    localparam int unsigned AW    = 4;
    localparam int unsigned SRSTN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] tx_evt = '0;
    logic [15:0] rx_evt = '0;
    logic        irq_tx, irq_rx, tx_run, rx_run, long_ok, reset_busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] rv;
    logic [31:0] ien_v;

    always #5 clk = ~clk;

    mac_csr_block #(.ADDR_W(AW), .SRST_CYCLES(SRSTN)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .irq_tx(irq_tx), .irq_rx(irq_rx), .tx_run(tx_run),
        .rx_run(rx_run), .long_ok(long_ok), .reset_busy(reset_busy)
    );

    function automatic logic [31:0] reset_value(int a);
        case (a)
            3, 4:    return 32'hFFFF_FFFC;
            7:       return 32'h0000_0101;
            8:       return 32'h0000_0800;
            9:       return 32'h0000_7FFF;
            10:      return 32'h0090_0000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        bus_addr  = AW'(a);
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        bus_addr = AW'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic pulse(input int b);
        @(negedge clk);
        if (b >= 16) tx_evt = 16'h1 << (b - 16);
        else         rx_evt = 16'h1 << b;
        @(negedge clk);
        tx_evt = '0;
        rx_evt = '0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values of every mapped word and quiet outputs
        for (int a = 0; a <= 10; a++) begin
            rd(a, rv);
            chk($sformatf("R1 word %0d reset value", a), rv, reset_value(a));
        end
        chk("R1 outputs low", {26'b0, irq_tx, irq_rx, tx_run, rx_run, long_ok, reset_busy}, 32'h0);

        // R9: unmapped addresses read zero and writes there touch nothing
        for (int a = 11; a < 16; a++) begin
            wr(a, 32'hFFFF_FFFF);
            rd(a, rv);
            chk($sformatf("R9 unmapped %0d reads zero", a), rv, 32'h0);
        end
        for (int a = 0; a <= 10; a++) begin
            rd(a, rv);
            chk($sformatf("R9 word %0d untouched", a), rv, reset_value(a));
        end

        // R7: unlocked after hard reset, low bits forced to zero
        wr(3, 32'h1000_0003);
        rd(3, rv); chk("R7 tx base unlocked write", rv, 32'h1000_0000);
        wr(4, 32'h2000_0006);
        rd(4, rv); chk("R7 rx base unlocked write", rv, 32'h2000_0004);

        // R2: command field decode
        wr(0, 32'h00FF_FEFE);
        rd(0, rv); chk("R2 only long bit kept", rv, 32'h0000_0002);
        chk("R2 outputs long only", {29'b0, tx_run, rx_run, long_ok}, 32'h1);
        wr(0, 32'h0000_0103);
        rd(0, rv); chk("R2 all command bits", rv, 32'h0000_0103);
        chk("R2 outputs all on", {29'b0, tx_run, rx_run, long_ok}, 32'h7);

        // R7: now locked
        wr(3, 32'h5555_0000);
        rd(3, rv); chk("R7 tx base locked", rv, 32'h1000_0000);
        wr(4, 32'h6666_0000);
        rd(4, rv); chk("R7 rx base locked", rv, 32'h2000_0004);

        // R8: plain storage words and read-only counter
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pat;
            pat = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'hA5A5_5A5A : (k == 2) ? 32'h0000_0001 : 32'h8000_0000;
            wr(5, pat);  rd(5, rv);  chk("R8 tx current pointer", rv, pat);
            wr(6, ~pat); rd(6, rv);  chk("R8 rx current pointer", rv, ~pat);
            wr(7, pat ^ 32'h1); rd(7, rv); chk("R8 fifo threshold", rv, pat ^ 32'h1);
            wr(8, pat + 32'h3); rd(8, rv); chk("R8 frame limit", rv, pat + 32'h3);
            wr(10, pat << 1);   rd(10, rv); chk("R8 mgmt word", rv, pat << 1);
            wr(9, pat);         rd(9, rv); chk("R8 counter read only", rv, 32'h0000_7FFF);
        end

        // R5 / R6: sweep every status bit
        for (int b = 0; b < 32; b++) begin
            ien_v = (b % 2 == 0) ? (32'h1 << b) : (32'h1 << (b ^ 1));
            wr(1, ien_v);
            pulse(b);
            rd(2, rv);
            chk($sformatf("R5 bit %0d set by event", b), rv, 32'h1 << b);
            chk($sformatf("R6 bit %0d irq tx", b), {31'b0, irq_tx}, {31'b0, (b >= 16) && (b % 2 == 0)});
            chk($sformatf("R6 bit %0d irq rx", b), {31'b0, irq_rx}, {31'b0, (b < 16) && (b % 2 == 0)});
            wr(2, ~(32'h1 << b));
            rd(2, rv);
            chk($sformatf("R5 bit %0d kept by zero write", b), rv, 32'h1 << b);
            wr(2, 32'h1 << b);
            rd(2, rv);
            chk($sformatf("R5 bit %0d cleared", b), rv, 32'h0);
            chk($sformatf("R6 bit %0d lines low after clear", b), {30'b0, irq_tx, irq_rx}, 32'h0);
        end

        // R5: event and clear collide in one cycle
        wr(1, 32'h0);
        pulse(5);
        pulse(20);
        @(negedge clk);
        bus_addr = AW'(2); bus_wdata = 32'h0000_0020; bus_wr = 1'b1; rx_evt = 16'h0020;
        @(negedge clk);
        bus_wr = 1'b0; rx_evt = '0;
        rd(2, rv); chk("R5 set wins over clear on same bit", rv, 32'h0010_0020);
        @(negedge clk);
        bus_addr = AW'(2); bus_wdata = 32'h0010_0000; bus_wr = 1'b1; rx_evt = 16'h0040;
        @(negedge clk);
        bus_wr = 1'b0; rx_evt = '0;
        rd(2, rv); chk("R5 clear tx bit while rx bit sets", rv, 32'h0000_0060);

        // R3: soft reset window
        wr(1, 32'h00FF_00FF);
        wr(0, 32'h0100_0103);
        for (int i = 0; i < SRSTN; i++) begin
            chk($sformatf("R3 busy cycle %0d", i), {31'b0, reset_busy}, 32'h1);
            rd(7, rv); chk($sformatf("R3 zero read cycle %0d", i), rv, 32'h0);
            @(negedge clk);
        end
        chk("R3 busy released", {31'b0, reset_busy}, 32'h0);
        for (int a = 0; a <= 10; a++) begin
            rd(a, rv);
            chk($sformatf("R3 word %0d after soft reset", a), rv, reset_value(a));
        end
        chk("R3 outputs low after soft reset", {27'b0, irq_tx, irq_rx, tx_run, rx_run, long_ok}, 32'h0);

        // R7: unlocked again by the soft reset
        wr(3, 32'h3000_0001);
        rd(3, rv); chk("R7 unlocked by soft reset", rv, 32'h3000_0000);

        // R4: writes and events inside the window are dropped
        wr(0, 32'h0100_0000);
        wr(1, 32'hFFFF_FFFF);
        pulse(18);
        pulse(4);
        wr(0, 32'h0000_0101);
        while (reset_busy) @(negedge clk);
        rd(1, rv); chk("R4 enable write dropped", rv, 32'h0);
        rd(2, rv); chk("R4 events dropped", rv, 32'h0);
        rd(0, rv); chk("R4 command write dropped", rv, 32'h0);
        rd(3, rv); chk("R4 base at reset value", rv, 32'hFFFF_FFFC);

        summary();
    end
endmodule